// File: doc/BRIEF.md
# 4B/5B Transmit Framing Encoder

This block sits at the start of a 100BASE-TX transmit path. It takes the nibble-wide transmit stream from a MAC, one nibble per 25 MHz clock, and turns it into one 5-bit code-group per clock. While no frame is being sent, it sends the idle code-group. When a frame starts, the first two nibbles are replaced by the start-of-stream delimiter pair. The data nibbles that follow are encoded one for one. After the frame, the end-of-stream delimiter pair is appended. The error code-group is sent for any data nibble that the MAC marks as errored.

A bypass control skips all encoding and framing. In that mode the raw 5-bit symbol is formed from the error input (as the top bit) and the four data bits. All code-groups are registered. Each output therefore describes the inputs sampled at the previous rising clock edge. Scrambling, serialization and line coding happen downstream and are not part of this block.

Top module: `tx4b5b_encoder`

## Requirements
- R1: During the data phase of a frame, with the error input low, the data nibbles 0x0 through 0xF give these code-groups in order: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R2: While the enable is low and no end delimiter is owed, the output is the idle code-group 11111. The error input and the data bits have no effect in this state.
- R3: The output is registered, so each code-group appears one clock after the nibble it stands for. The first two nibbles sampled with the enable high after idle are sent as 11000 and then 10001. Their data and error inputs are not used.
- R4: In the first clock sampled with the enable low after a frame, the output is 01101, and in the next clock it is 00111. The enable input has no effect on the second of these. A frame that ends after a single nibble gives 11000 and then 01101.
- R5: After 00111, the next output is 11111 even when the enable is already high again. A nibble sampled in that clock is dropped. A new frame then starts with 11000.
- R6: In the data phase, a nibble sampled with the error input high is sent as 00100 in place of its encoding.
- R7: With bypass high, the output one clock later is {error input, data[3:0]}, with the error input as bit 4. This holds whatever the enable does. Bypass also returns the framing to idle, so the first non-bypass nibble with the enable high gives 11000.
- R8: A synchronous active-high reset makes the output 11111 and the framing idle, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Nibble clock; all inputs are sampled on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| tx_en_i | input | 1 | Frame enable from the MAC |
| tx_er_i | input | 1 | Transmit error flag; bit 4 of the raw symbol in bypass |
| txd_i | input | 4 | Transmit data nibble |
| bypass_i | input | 1 | Raw-symbol mode; skips encoding and framing |
| code_o | output | 5 | Registered 5-bit code-group |

## Verification
The vector walk uses several kinds of stimulus, each aimed at a different fault:
- Long frames that carry every data value catch errors in the mapping.
- A one-nibble frame, and an enable that returns high during the end delimiter, catch start and end sequencing that is off by one clock.
- An error pulse in the idle state, compared with one inside a frame, shows whether the error code-group is gated by the frame phase.
- Bypass runs, entered in the middle of a frame and then left, show whether the raw path uses the right bit order and whether it resets the framing.

Randomised frames with random error pulses and gaps are then compared against a model that builds the expected delimiter, data and idle sequence from each frame's length.

// File: rtl/tx4b5b_pkg.sv
package tx4b5b_pkg;
  localparam int NIB_W = 4;
  localparam int SYM_W = NIB_W + 1;

  localparam logic [SYM_W-1:0] SYM_IDLE  = 5'b11111;
  localparam logic [SYM_W-1:0] SYM_SSD1  = 5'b11000;
  localparam logic [SYM_W-1:0] SYM_SSD2  = 5'b10001;
  localparam logic [SYM_W-1:0] SYM_ESD1  = 5'b01101;
  localparam logic [SYM_W-1:0] SYM_ESD2  = 5'b00111;
  localparam logic [SYM_W-1:0] SYM_ERROR = 5'b00100;

  // framing phase: what has just been sent
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SSD1,
    PH_DATA,
    PH_ESD1,
    PH_ESD2
  } phase_t;

  // which symbol the output register loads
  typedef enum logic [2:0] {
    SEL_IDLE,
    SEL_SSD1,
    SEL_SSD2,
    SEL_DATA,
    SEL_ERROR,
    SEL_ESD1,
    SEL_ESD2,
    SEL_RAW
  } sel_t;
endpackage

// File: rtl/tx4b5b_nibble_map.sv
module tx4b5b_nibble_map
  import tx4b5b_pkg::*;
(
  input  logic [NIB_W-1:0] nib_i,
  output logic [SYM_W-1:0] sym_o
);
  always_comb begin
    unique case (nib_i)
      4'h0: sym_o = 5'b11110;
      4'h1: sym_o = 5'b01001;
      4'h2: sym_o = 5'b10100;
      4'h3: sym_o = 5'b10101;
      4'h4: sym_o = 5'b01010;
      4'h5: sym_o = 5'b01011;
      4'h6: sym_o = 5'b01110;
      4'h7: sym_o = 5'b01111;
      4'h8: sym_o = 5'b10010;
      4'h9: sym_o = 5'b10011;
      4'hA: sym_o = 5'b10110;
      4'hB: sym_o = 5'b10111;
      4'hC: sym_o = 5'b11010;
      4'hD: sym_o = 5'b11011;
      4'hE: sym_o = 5'b11100;
      default: sym_o = 5'b11101;
    endcase
  end
endmodule

// File: rtl/tx4b5b_frame_ctl.sv
module tx4b5b_frame_ctl
  import tx4b5b_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic tx_en_i,
  input  logic tx_er_i,
  input  logic bypass_i,
  output sel_t sel_o
);
  phase_t ph_q, ph_d;

  always_comb begin
    sel_o = SEL_IDLE;
    ph_d  = PH_IDLE;
    if (bypass_i) begin
      sel_o = SEL_RAW;
      ph_d  = PH_IDLE;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (tx_en_i) begin
            sel_o = SEL_SSD1;
            ph_d  = PH_SSD1;
          end
        end
        PH_SSD1: begin
          if (tx_en_i) begin
            sel_o = SEL_SSD2;
            ph_d  = PH_DATA;
          end else begin
            sel_o = SEL_ESD1;
            ph_d  = PH_ESD1;
          end
        end
        PH_DATA: begin
          if (tx_en_i) begin
            sel_o = tx_er_i ? SEL_ERROR : SEL_DATA;
            ph_d  = PH_DATA;
          end else begin
            sel_o = SEL_ESD1;
            ph_d  = PH_ESD1;
          end
        end
        PH_ESD1: begin
          sel_o = SEL_ESD2;
          ph_d  = PH_ESD2;
        end
        default: begin
          sel_o = SEL_IDLE;
          ph_d  = PH_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) ph_q <= PH_IDLE;
    else       ph_q <= ph_d;
  end
endmodule

// File: rtl/tx4b5b_symbol_reg.sv
module tx4b5b_symbol_reg
  import tx4b5b_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  sel_t             sel_i,
  input  logic [SYM_W-1:0] data_sym_i,
  input  logic [SYM_W-1:0] raw_sym_i,
  output logic [SYM_W-1:0] code_o
);
  logic [SYM_W-1:0] nxt;

  always_comb begin
    unique case (sel_i)
      SEL_SSD1:  nxt = SYM_SSD1;
      SEL_SSD2:  nxt = SYM_SSD2;
      SEL_DATA:  nxt = data_sym_i;
      SEL_ERROR: nxt = SYM_ERROR;
      SEL_ESD1:  nxt = SYM_ESD1;
      SEL_ESD2:  nxt = SYM_ESD2;
      SEL_RAW:   nxt = raw_sym_i;
      default:   nxt = SYM_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) code_o <= SYM_IDLE;
    else       code_o <= nxt;
  end
endmodule

// File: rtl/tx4b5b_encoder.sv
module tx4b5b_encoder
  import tx4b5b_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tx_en_i,
  input  logic             tx_er_i,
  input  logic [NIB_W-1:0] txd_i,
  input  logic             bypass_i,
  output logic [SYM_W-1:0] code_o
);
  sel_t             sel;
  logic [SYM_W-1:0] data_sym;
  logic [SYM_W-1:0] raw_sym;

  assign raw_sym = {tx_er_i, txd_i};

  tx4b5b_nibble_map u_map (
    .nib_i (txd_i),
    .sym_o (data_sym)
  );

  tx4b5b_frame_ctl u_ctl (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .tx_en_i  (tx_en_i),
    .tx_er_i  (tx_er_i),
    .bypass_i (bypass_i),
    .sel_o    (sel)
  );

  tx4b5b_symbol_reg u_out (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .sel_i      (sel),
    .data_sym_i (data_sym),
    .raw_sym_i  (raw_sym),
    .code_o     (code_o)
  );
endmodule

// File: rtl/tx4b5b_encoder_chk.sv
module tx4b5b_encoder_chk
  import tx4b5b_pkg::*;
(
  input logic             clk_i,
  input logic             rst_i,
  input logic             tx_en_i,
  input logic             tx_er_i,
  input logic [NIB_W-1:0] txd_i,
  input logic             bypass_i,
  input logic [SYM_W-1:0] code_o
);
  logic framed;  // current code_o came from the framing path
  always_ff @(posedge clk_i) begin
    if (rst_i) framed <= 1'b1;
    else       framed <= !bypass_i;
  end

  // R7
  raw_symbol_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    bypass_i |=> code_o == $past({tx_er_i, txd_i}));

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (framed && code_o == SYM_IDLE && !bypass_i && !tx_en_i) |=> code_o == SYM_IDLE);

  // R3
  ssd_pair_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (framed && code_o == SYM_SSD1 && !bypass_i && tx_en_i) |=> code_o == SYM_SSD2);

  // R4
  esd_pair_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (framed && code_o == SYM_ESD1 && !bypass_i) |=> code_o == SYM_ESD2);

  // R5
  gap_after_esd_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (framed && code_o == SYM_ESD2 && !bypass_i) |=> code_o == SYM_IDLE);

  // R6
  err_symbol_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (framed && !bypass_i && tx_en_i && tx_er_i &&
     code_o != SYM_IDLE && code_o != SYM_SSD1 && code_o != SYM_ESD1 &&
     code_o != SYM_ESD2) |=> code_o == SYM_ERROR);
endmodule

bind tx4b5b_encoder tx4b5b_encoder_chk u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .tx_en_i  (tx_en_i),
  .tx_er_i  (tx_er_i),
  .txd_i    (txd_i),
  .bypass_i (bypass_i),
  .code_o   (code_o)
);

// File: tb/test_tx4b5b_encoder.sv
module test_tx4b5b_encoder;
  localparam int PERIOD = 10;
  localparam int NVEC = 30;
  // {bypass, en, er, d[3:0], expected[4:0]}
  localparam logic [11:0] VEC [NVEC] = '{
    12'b0_0_0_0000_11111, // R2 idle
    12'b0_0_1_0101_11111, // R2 error ignored while idle
    12'b0_1_0_0101_11000, // R3 first nibble
    12'b0_1_1_0101_10001, // R3 second nibble, error unused
    12'b0_1_0_0101_01011, // R1 5
    12'b0_1_0_1101_11011, // R1 D
    12'b0_1_0_0000_11110, // R1 0
    12'b0_1_1_0011_00100, // R6
    12'b0_1_0_1111_11101, // R1 F
    12'b0_1_0_1000_10010, // R1 8
    12'b0_0_0_0000_01101, // R4 T
    12'b0_0_0_0000_00111, // R4 R
    12'b0_0_0_0000_11111, // R2
    12'b0_1_0_0101_11000, // R3 one-nibble frame
    12'b0_0_0_0000_01101, // R4 T after J
    12'b0_1_0_0101_00111, // R4 R despite enable
    12'b0_1_0_0101_11111, // R5 gap
    12'b0_1_0_0101_11000, // R5 new J
    12'b0_1_0_0101_10001, // R3
    12'b0_1_0_0001_01001, // R1 1
    12'b0_1_0_1010_10110, // R1 A
    12'b1_1_1_1010_11010, // R7 raw mid-frame
    12'b1_0_0_0011_00011, // R7
    12'b1_1_0_0101_00101, // R7
    12'b0_1_0_0101_11000, // R7 framing back at idle
    12'b0_1_0_0101_10001, // R3
    12'b0_1_0_0111_01111, // R1 7
    12'b0_0_0_0000_01101, // R4
    12'b0_0_0_0000_00111, // R4
    12'b0_0_0_0000_11111  // R2
  };
  localparam logic [4:0] MAP [16] = '{
    5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011, 5'b01110, 5'b01111,
    5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11010, 5'b11011, 5'b11100, 5'b11101};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, er = 1'b0, byp = 1'b0;
  logic [3:0] d = 4'h0;
  logic [4:0] code;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  tx4b5b_encoder i_tx4b5b_encoder (
    .clk_i(clk), .rst_i(rst), .tx_en_i(en), .tx_er_i(er),
    .txd_i(d), .bypass_i(byp), .code_o(code));

  task automatic check(input logic [4:0] exp, input string req);
    total++;
    if (code !== exp) begin
      bad++;
      $display("FAIL %s: code=%b expected=%b", req, code, exp);
    end
  endtask

  task automatic step(input logic b, input logic e, input logic r,
                      input logic [3:0] n, input logic [4:0] exp, input string req);
    @(negedge clk);
    byp = b; en = e; er = r; d = n;
    @(posedge clk);
    #1 check(exp, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    // R8 reset state
    repeat (3) @(posedge clk);
    #1 check(5'b11111, "R8 reset");
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++)
      step(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8:5], VEC[i][4:0], "R1-table");

    // R8 reset in mid-frame
    step(0, 1, 0, 4'h2, 5'b11000, "R8 pre");
    step(0, 1, 0, 4'h2, 5'b10001, "R8 pre");
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1 check(5'b11111, "R8 mid-frame reset");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1 check(5'b11000, "R8 restart J");
    step(0, 0, 0, 4'h0, 5'b01101, "R4");
    step(0, 0, 0, 4'h0, 5'b00111, "R4");
    step(0, 0, 0, 4'h0, 5'b11111, "R2");

    // all data values, R1
    step(0, 1, 0, 4'h0, 5'b11000, "R3");
    step(0, 1, 0, 4'h0, 5'b10001, "R3");
    for (int v = 0; v < 16; v++)
      step(0, 1, 0, 4'(v), MAP[v], "R1 sweep");
    step(0, 0, 0, 4'h0, 5'b01101, "R4");
    step(0, 0, 0, 4'h0, 5'b00111, "R4");
    step(0, 0, 0, 4'h0, 5'b11111, "R5");

    // random frames against the frame model
    for (int f = 0; f < 200; f++) begin
      int len;
      int gap;
      len = 2 + int'($urandom_range(0, 20));
      gap = 3 + int'($urandom_range(0, 2));
      for (int k = 0; k < len; k++) begin
        logic [3:0] nb;
        logic ebit;
        logic [4:0] exp;
        nb = 4'($urandom);
        ebit = ($urandom_range(0, 7) == 0);
        if (k == 0) exp = 5'b11000;
        else if (k == 1) exp = 5'b10001;
        else if (ebit) exp = 5'b00100;
        else exp = MAP[nb];
        step(0, 1, ebit, nb, exp, "R6 random frame");
      end
      for (int g = 0; g < gap; g++) begin
        logic [4:0] exp;
        exp = (g == 0) ? 5'b01101 : (g == 1) ? 5'b00111 : 5'b11111;
        step(0, 0, 1'($urandom), 4'($urandom), exp, "R4 random gap");
      end
    end
    finish_run();
  end
endmodule